// File: doc/BRIEF.md
# DRAM Channel Traffic Counter

This block watches one channel of a memory controller and tallies the traffic it sees. Three single-cycle strobes come from the controller's command side: a read command, a write command, and a tick that marks one memory clock cycle. While counting is switched on, four free-running counters advance: writes, reads, memory clock cycles, and all accesses (reads plus writes). Software reaches the block through a plain register bus (address, write enable, write data, read data). Reads are combinational, so `bus_rdata` reflects the addressed register in the same cycle. The monitor only observes and never changes the traffic.

The control register is written through a bit mask. Bits [31:16] of the write word select which bits of [15:0] take the new value, so a driver can flip a single bit without a read-modify-write. Counting is governed by a two-state machine. `MON_HALTED` is the reset state. The transition START moves to `MON_COUNTING` on a control write whose mask bit 17 and data bit 1 are both 1. The transition STOP moves back to `MON_HALTED` on a control write whose mask bit 17 is 1 and whose data bit 1 is 0. Every other cycle holds the state. The counters are never cleared except by reset and wrap silently, so software works with the differences between successive samples.

Top module: `dram_traffic_monitor`

## Requirements
- R1: A synchronous active-high reset sets the control register and all four counters to zero, leaving the machine in `MON_HALTED`.
- R2: The control register is at offset 0x04. A write there updates control bit k (k = 0..5) only when write-data bit k+16 is 1, and every other bit keeps its value. The bits are: 0 timer-count enable, 1 run (the state; 1 = `MON_COUNTING`), 2 low-power DDR2/3 type, 3 hardware enable, 4 low-power DDR4 type, 5 DDR4 type. Bits [31:6] always read as zero.
- R3: The memory-type bits 2, 4 and 5 form one field, and a single masked write may change all three together.
- R4: The counters move only on a clock edge at which the run bit was already 1 before that edge. A strobe in the same cycle as the START write is not counted, and a strobe in the same cycle as the STOP write is counted.
- R5: The write counter (offset 0x20) adds 1 per cycle with `ev_wr` high. The read counter (offset 0x24) adds 1 per cycle with `ev_rd` high.
- R6: The cycle counter (offset 0x28) adds 1 per cycle with `ev_tick` high.
- R7: The access counter (offset 0x2c) adds the number of read and write strobes high in that cycle: 0, 1 or 2.
- R8: Each counter is CNT_W bits wide (32 by default) and wraps modulo 2^CNT_W. Its value reads back zero-extended to 32 bits.
- R9: STOP freezes the counters without clearing them, and a later START resumes from the frozen values.
- R10: Reads of any offset other than 0x04, 0x20, 0x24, 0x28 and 0x2c return zero. Writes to the counter offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_wdata | input | 32 | Write data; bits [31:16] are the per-bit mask |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_rd | input | 1 | Read command seen this cycle |
| ev_wr | input | 1 | Write command seen this cycle |
| ev_tick | input | 1 | Memory clock cycle tick |

## Verification
Two functions can land in the same cycle: a control write that starts or stops counting, and the traffic strobes that the counters consume. The bench drives strobes in exactly the cycles that carry the START and STOP writes, and also mixes random control writes into random traffic. It compares every counter against a bench model that applies the run bit as it stood before the edge. A narrowed counter width in the bench pushes the access counter through its wrap point within the run.

// File: rtl/mon_pkg.sv
package mon_pkg;
    localparam int BUS_W      = 32;
    localparam int MASK_LSB   = 16;
    localparam int CTRL_BITS  = 6;
    localparam int NUM_CNT    = 4;
    localparam int INC_W      = 2;
    localparam int RUN_BIT    = 1;

    localparam logic [7:0] CTRL_OFS = 8'h04;
    localparam logic [7:0] CNT_BASE = 8'h20;

    typedef enum logic {
        MON_HALTED   = 1'b0,
        MON_COUNTING = 1'b1
    } run_state_e;
endpackage

// File: rtl/mon_ctrl_reg.sv
module mon_ctrl_reg
    import mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [BUS_W-1:0]     wdata,
    output logic [CTRL_BITS-1:0] ctrl_o,
    output logic                 running
);
    localparam int RUN_MASK = MASK_LSB + RUN_BIT;

    run_state_e state_q, state_d;
    logic [CTRL_BITS-1:0] bits_q, bits_d;
    logic [CTRL_BITS-1:0] wmask, wval;

    assign wmask = wdata[MASK_LSB +: CTRL_BITS];
    assign wval  = wdata[CTRL_BITS-1:0];

    always_ff @(posedge clk) begin
        if (rst) state_q <= MON_HALTED;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_HALTED:   if (wr_en && wdata[RUN_MASK] && wdata[RUN_BIT])  state_d = MON_COUNTING;
            MON_COUNTING: if (wr_en && wdata[RUN_MASK] && !wdata[RUN_BIT]) state_d = MON_HALTED;
            default:      state_d = MON_HALTED;
        endcase
    end

    always_comb begin
        bits_d = bits_q;
        if (wr_en) bits_d = (bits_q & ~wmask) | (wval & wmask);
        bits_d[RUN_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= bits_d;
    end

    always_comb begin
        ctrl_o          = bits_q;
        ctrl_o[RUN_BIT] = (state_q == MON_COUNTING);
        running         = (state_q == MON_COUNTING);
    end

    // R2: without a control write the register holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_o));
    // R9: STOP always lands in the halted state
    a_r9_stop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[RUN_MASK] && !wdata[RUN_BIT]) |=> !running);
endmodule

// File: rtl/mon_counter.sv
module mon_counter #(
    parameter int CNT_W = 32,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)     count <= '0;
        else if (en) count <= count + CNT_W'(inc);
    end

    // R4: frozen while not enabled
    a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));
    // R8: modular step by the increment
    a_r8_step: assert property (@(posedge clk) disable iff (rst)
        en |=> (count == CNT_W'($past(count) + CNT_W'($past(inc)))));
endmodule

// File: rtl/dram_traffic_monitor.sv
module dram_traffic_monitor
    import mon_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_rd,
    input  logic              ev_wr,
    input  logic              ev_tick
);
    localparam int IDX_WR  = 0;
    localparam int IDX_RD  = 1;
    localparam int IDX_CYC = 2;
    localparam int IDX_ACC = 3;

    logic [CTRL_BITS-1:0] ctrl;
    logic                 running;
    logic                 ctrl_wr;
    logic [INC_W-1:0]     inc [NUM_CNT];
    logic [CNT_W-1:0]     cnt [NUM_CNT];

    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));

    mon_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr),
        .wdata   (bus_wdata),
        .ctrl_o  (ctrl),
        .running (running)
    );

    always_comb begin
        inc[IDX_WR]  = INC_W'(ev_wr);
        inc[IDX_RD]  = INC_W'(ev_rd);
        inc[IDX_CYC] = INC_W'(ev_tick);
        inc[IDX_ACC] = INC_W'(ev_rd) + INC_W'(ev_wr);
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        mon_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .en    (running),
            .inc   (inc[g]),
            .count (cnt[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFS))
            bus_rdata = BUS_W'(ctrl);
        for (int i = 0; i < NUM_CNT; i++)
            if (bus_addr == ADDR_W'(CNT_BASE) + ADDR_W'(4 * i))
                bus_rdata = BUS_W'(cnt[i]);
    end

    // R7: access counter moves by exactly the read delta plus the write delta
    a_r7_access_sum: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (CNT_W'(cnt[IDX_ACC] - $past(cnt[IDX_ACC])) ==
                  CNT_W'((cnt[IDX_RD] - $past(cnt[IDX_RD])) + (cnt[IDX_WR] - $past(cnt[IDX_WR])))));
    // R5: write and read counters step by at most one per cycle
    a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (CNT_W'(cnt[IDX_WR] - $past(cnt[IDX_WR])) <= CNT_W'(1)) &&
                 (CNT_W'(cnt[IDX_RD] - $past(cnt[IDX_RD])) <= CNT_W'(1)));
endmodule

// File: tb/dram_traffic_monitor_bench.sv
module dram_traffic_monitor_bench;
    localparam int CW = 10;
    localparam logic [31:0] CMASK = (32'd1 << CW) - 32'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic ev_rd = 1'b0, ev_wr = 1'b0, ev_tick = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0]  m_ctrl;
    logic [31:0] m_wr, m_rd, m_cyc, m_acc;

    always #10 clk = ~clk;

    dram_traffic_monitor #(.ADDR_W(8), .CNT_W(CW)) u_dram_traffic_monitor (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_tick(ev_tick));

    // reference model, built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0; m_wr = '0; m_rd = '0; m_cyc = '0; m_acc = '0;
        end else begin
            if (m_ctrl[1]) begin
                m_wr  = (m_wr  + 32'(ev_wr))  & CMASK;
                m_rd  = (m_rd  + 32'(ev_rd))  & CMASK;
                m_cyc = (m_cyc + 32'(ev_tick)) & CMASK;
                m_acc = (m_acc + 32'(ev_rd) + 32'(ev_wr)) & CMASK;
            end
            if (bus_we && bus_addr == 8'h04)
                m_ctrl = (m_ctrl & ~bus_wdata[21:16]) | (bus_wdata[5:0] & bus_wdata[21:16]);
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h04:   return {26'd0, m_ctrl};
            8'h20:   return m_wr;
            8'h24:   return m_rd;
            8'h28:   return m_cyc;
            8'h2c:   return m_acc;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic r, input logic w, input logic t);
        bus_we = we; bus_addr = a; bus_wdata = d;
        ev_rd = r; ev_wr = w; ev_tick = t;
        @(negedge clk);
        bus_we = 1'b0; ev_rd = 1'b0; ev_wr = 1'b0; ev_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] snap;
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ctrl", 32'(0), 32'(0) | bus_rdata & 32'd0);
        rd_chk(8'h04, "R1 ctrl reset");
        rd_chk(8'h20, "R1 wr reset");
        rd_chk(8'h24, "R1 rd reset");
        rd_chk(8'h28, "R1 cyc reset");
        rd_chk(8'h2c, "R1 acc reset");
        rd_chk(8'h00, "R10 unmapped");
        // R2 masked writes
        cyc(1, 8'h04, 32'h003D_0015, 0, 0, 0);
        rd_chk(8'h04, "R2 full mask");
        chk("R2 value", bus_rdata, 32'h15);
        cyc(1, 8'h04, 32'h0001_0000, 0, 0, 0);
        rd_chk(8'h04, "R2 single bit");
        chk("R2 kept", bus_rdata, 32'h14);
        cyc(1, 8'h04, 32'h0000_003F, 0, 0, 0);
        rd_chk(8'h04, "R2 zero mask");
        cyc(1, 8'h04, 32'hFFC0_FFC0, 0, 0, 0);
        rd_chk(8'h04, "R2 upper bits zero");
        // R3 type field in one write
        cyc(1, 8'h04, 32'h0034_0020, 0, 0, 0);
        rd_chk(8'h04, "R3 type field");
        chk("R3 value", bus_rdata, 32'h20);
        // R4 halted: no counting
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0, 1, 1, 1);
        rd_chk(8'h2c, "R4 halted acc");
        chk("R4 halted zero", bus_rdata, 32'd0);
        // R4 strobe in START cycle not counted
        cyc(1, 8'h04, 32'h0002_0002, 1, 1, 1);
        rd_chk(8'h2c, "R4 start cycle");
        chk("R4 start zero", bus_rdata, 32'd0);
        // R5 R6 R7 directed
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 1, 0, 0);
        for (int i = 0; i < 2; i++) cyc(0, 8'h00, 0, 0, 1, 1);
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 0, 1, 1, 1);
        rd_chk(8'h20, "R5 wr");  chk("R5 wr value", bus_rdata, 32'd6);
        rd_chk(8'h24, "R5 rd");  chk("R5 rd value", bus_rdata, 32'd7);
        rd_chk(8'h28, "R6 cyc"); chk("R6 cyc value", bus_rdata, 32'd6);
        rd_chk(8'h2c, "R7 acc"); chk("R7 acc value", bus_rdata, 32'd13);
        // R4 strobe in STOP cycle counted, R9 freeze
        cyc(1, 8'h04, 32'h0002_0000, 1, 1, 1);
        rd_chk(8'h2c, "R4 stop cycle"); chk("R4 stop counted", bus_rdata, 32'd15);
        snap = bus_rdata;
        for (int i = 0; i < 6; i++) cyc(0, 8'h00, 0, 1, 1, 1);
        rd_chk(8'h2c, "R9 frozen"); chk("R9 frozen value", bus_rdata, snap);
        // R10 counter writes ignored
        cyc(1, 8'h20, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 8'h2c, 32'h0000_0000, 0, 0, 0);
        rd_chk(8'h20, "R10 wr ignored");
        rd_chk(8'h2c, "R10 acc ignored"); chk("R10 acc value", bus_rdata, snap);
        rd_chk(8'h30, "R10 unmapped 30");
        // R9 restart resumes
        cyc(1, 8'h04, 32'h0002_0002, 0, 0, 0);
        cyc(0, 8'h00, 0, 1, 0, 0);
        rd_chk(8'h2c, "R9 resume"); chk("R9 resume value", bus_rdata, snap + 32'd1);
        // R8 wrap
        for (int i = 0; i < 600; i++) cyc(0, 8'h00, 0, 1, 1, 1);
        rd_chk(8'h2c, "R8 wrap acc");
        chk("R8 wrap value", bus_rdata, (snap + 32'd1201) & CMASK);
        rd_chk(8'h28, "R8 cyc");
        // random traffic with random control writes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (rv[3:0] == 4'h0)
                cyc(1, 8'h04, {10'd0, rv[21:16], 10'd0, rv[9:4]}, rv[24], rv[25], rv[26]);
            else if (rv[3:0] == 4'h1)
                cyc(1, {2'b00, rv[29:27], 3'b000} | 8'h20, rv, rv[24], rv[25], rv[26]);
            else
                cyc(0, 8'h00, 0, rv[24], rv[25], rv[26]);
            if (i % 8 == 7) begin
                rd_chk(8'h04, "R2 random ctrl");
                rd_chk(8'h20, "R5 random wr");
                rd_chk(8'h24, "R5 random rd");
                rd_chk(8'h28, "R6 random cyc");
                rd_chk(8'h2c, "R7 random acc");
                rd_chk(8'(rv[31:28]) | 8'h40, "R10 random unmapped");
            end
        end
        // R1 reset again clears all
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk(8'h04, "R1 ctrl re-reset");
        rd_chk(8'h2c, "R1 acc re-reset"); chk("R1 acc zero", bus_rdata, 32'd0);
        finish_run();
    end
endmodule